// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration front end of a legacy I/O controller. A host reaches it through two byte-wide I/O addresses. The index port is at 0x2E and the data port is at 0x2F. After reset the port is locked. Writes to the data port do nothing, and reads return 0xFF. The port opens only after a four-byte key is written to the index port. Once open, the host writes a register index to the index port and then reads or writes that register through the data port.

Some registers are global: a logical device selector, a chip identifier and a revision. The others belong to one logical device each, chosen by the selector. Each device has an activation bit and a 16-bit base address. These per-device values drive the block's outputs continuously, so the downstream devices can use them. A dedicated exit write locks the port again.

The host bus is a plain strobe interface: one cycle of `io_wr` is one write. Read data is combinational while `io_rd` is high. There is no back-pressure; every strobe is accepted in the cycle it is presented.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the port is locked, `cfg_ldn` is 0, every `dev_enable` bit is 0 and every base address is 0. `io_rdata` is 0xFF whenever `io_rd` is low.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to address 0x2E, in that order, sets `cfg_unlocked` in the cycle after the fourth write. Any byte that does not match its place in the key returns the matcher to its start state, and that byte does not count as a first key byte.
- R3: While the port is locked, data-port writes change no state. Index-port writes only feed the key matcher. Reads of 0x2E and 0x2F return 0xFF.
- R4: While the port is unlocked, the index register keeps the last byte written to 0x2E, and reading 0x2E returns it.
- R5: A data write of 0x02 while the index is 0x02 locks the port from the next cycle. Any other data value at index 0x02 leaves the port unlocked.
- R6: Index 0x07 is the logical device selector. It can be read and written, and its value is driven on `cfg_ldn`.
- R7: Index 0x20 reads the high byte of CHIP_ID and index 0x21 reads the low byte. Index 0x22 reads CHIP_REV in bits 3:0, with bits 7:4 zero. Writes to these indices are ignored.
- R8: Index 0x30 holds the activation bit (bit 0) of the selected device. It reads back as {7'b0, bit} and drives `dev_enable[ldn]`.
- R9: Index 0x60 holds the high byte and index 0x61 the low byte of the selected device's base address. The address is driven on `dev_base[ldn*16 +: 16]`.
- R10: When the selector is NUM_DEV or above, writes to 0x30, 0x60 and 0x61 are ignored and reads of them return 0xFF. Any index not listed above reads 0xFF. I/O addresses other than 0x2E and 0x2F read 0xFF and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when idle or not decoded |
| cfg_unlocked | output | 1 | Configuration mode is open |
| cfg_ldn | output | 8 | Selected logical device number |
| dev_enable | output | NUM_DEV | Activation bit per device |
| dev_base | output | NUM_DEV*16 | Base address per device, device d at bits d*16 +: 16 |

## Verification
A key matcher stuck in a wrong state shows up when `cfg_unlocked` rises one cycle after the wrong write, or fails to rise after the right fourth write. A locked or unlocked flag with the wrong value is seen on the next read of either port: the read returns 0xFF when it should return data, or data when it should return 0xFF. An index or selector register that drifts makes the very next data read return the wrong register or the wrong device. Wrong per-device state appears on `dev_enable` or `dev_base` one cycle after the write that caused it.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;
  localparam logic [15:0] IDX_PORT  = 16'h002E;
  localparam logic [15:0] DATA_PORT = 16'h002F;
  localparam int unsigned KEY_LEN   = 4;

  localparam logic [7:0] RI_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_VALUE = 8'h02;
  localparam logic [7:0] RI_LDN     = 8'h07;
  localparam logic [7:0] RI_ID_HI   = 8'h20;
  localparam logic [7:0] RI_ID_LO   = 8'h21;
  localparam logic [7:0] RI_REV     = 8'h22;
  localparam logic [7:0] RI_ACT     = 8'h30;
  localparam logic [7:0] RI_BASE_HI = 8'h60;
  localparam logic [7:0] RI_BASE_LO = 8'h61;

  function automatic logic [7:0] key_at(input int unsigned pos);
    case (pos)
      0:       key_at = 8'h87;
      1:       key_at = 8'h01;
      default: key_at = 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_matcher.sv
module cfg_key_matcher
  import cfg_keyport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       key_done
);
  localparam int ST_W = $clog2(KEY_LEN);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(KEY_LEN - 1);

  logic [ST_W-1:0] st_q;
  logic            match;

  assign match    = byte_in == key_at(int'(st_q));
  assign key_done = byte_vld && match && (st_q == ST_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      st_q <= '0;
    else if (byte_vld) begin
      if (!match || st_q == ST_LAST)
        st_q <= '0;
      else
        st_q <= st_q + 1'b1;
    end
  end

  // R2
  key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !match) |=> (st_q == '0));
  // R2
  key_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(st_q));
endmodule

// File: rtl/cfg_dev_regs.sv
module cfg_dev_regs
  import cfg_keyport_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           ldn,
  input  logic [7:0]           reg_idx,
  input  logic [7:0]           wdata,
  output logic [NUM_DEV-1:0]   dev_enable,
  output logic [NUM_DEV*16-1:0] dev_base,
  output logic                 sel_valid,
  output logic                 sel_en,
  output logic [15:0]          sel_base
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic        hit;
    logic        en_q;
    logic [15:0] base_q;

    assign hit = wr_en && (ldn == 8'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        base_q <= '0;
      end else if (hit) begin
        if (reg_idx == RI_ACT)     en_q         <= wdata[0];
        if (reg_idx == RI_BASE_HI) base_q[15:8] <= wdata;
        if (reg_idx == RI_BASE_LO) base_q[7:0]  <= wdata;
      end
    end

    assign dev_enable[g]        = en_q;
    assign dev_base[g*16 +: 16] = base_q;
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_en    = 1'b0;
    sel_base  = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (ldn == 8'(d)) begin
        sel_valid = 1'b1;
        sel_en    = dev_enable[d];
        sel_base  = dev_base[d*16 +: 16];
      end
    end
  end

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(dev_enable));
  // R10
  no_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ldn >= 8'(NUM_DEV)) |-> ($stable(dev_enable) && $stable(dev_base)));
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfg_keyport_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'h5A17,
  parameter logic [3:0]  CHIP_REV = 4'h6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_unlocked,
  output logic [7:0]            cfg_ldn,
  output logic [NUM_DEV-1:0]    dev_enable,
  output logic [NUM_DEV*16-1:0] dev_base
);
  logic       open_q;
  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic       wr_idx, wr_dat, key_done, exit_wr;
  logic       sel_valid, sel_en;
  logic [15:0] sel_base;
  logic [7:0] rd_val;

  assign wr_idx  = io_wr && (io_addr == IDX_PORT);
  assign wr_dat  = io_wr && (io_addr == DATA_PORT);
  assign exit_wr = wr_dat && open_q && (idx_q == RI_EXIT) && (io_wdata == EXIT_VALUE);

  cfg_key_matcher u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (wr_idx && !open_q),
    .byte_in  (io_wdata),
    .key_done (key_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
      ldn_q  <= '0;
    end else begin
      if (key_done)     open_q <= 1'b1;
      else if (exit_wr) open_q <= 1'b0;
      if (wr_idx && open_q) idx_q <= io_wdata;
      if (wr_dat && open_q && idx_q == RI_LDN) ldn_q <= io_wdata;
    end
  end

  cfg_dev_regs #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_dat && open_q),
    .ldn        (ldn_q),
    .reg_idx    (idx_q),
    .wdata      (io_wdata),
    .dev_enable (dev_enable),
    .dev_base   (dev_base),
    .sel_valid  (sel_valid),
    .sel_en     (sel_en),
    .sel_base   (sel_base)
  );

  always_comb begin
    rd_val = 8'hFF;
    if (open_q) begin
      if (io_addr == IDX_PORT)
        rd_val = idx_q;
      else if (io_addr == DATA_PORT) begin
        case (idx_q)
          RI_LDN:     rd_val = ldn_q;
          RI_ID_HI:   rd_val = CHIP_ID[15:8];
          RI_ID_LO:   rd_val = CHIP_ID[7:0];
          RI_REV:     rd_val = {4'h0, CHIP_REV};
          RI_ACT:     rd_val = sel_valid ? {7'b0, sel_en} : 8'hFF;
          RI_BASE_HI: rd_val = sel_valid ? sel_base[15:8] : 8'hFF;
          RI_BASE_LO: rd_val = sel_valid ? sel_base[7:0] : 8'hFF;
          default:    rd_val = 8'hFF;
        endcase
      end
    end
  end

  assign io_rdata     = io_rd ? rd_val : 8'hFF;
  assign cfg_unlocked = open_q;
  assign cfg_ldn      = ldn_q;

  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(io_wr && io_addr == IDX_PORT && io_wdata == 8'h55));
  // R5
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> $past(io_wr && io_addr == DATA_PORT && io_wdata == EXIT_VALUE));
  // R3
  locked_ldn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!open_q) |-> ($stable(ldn_q) && $stable(idx_q)));
  // R3
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && (io_addr == IDX_PORT || io_addr == DATA_PORT)) |-> (io_rdata == 8'hFF));
endmodule

// File: tb/cfg_keyport_tb.sv
module cfg_keyport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 4;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;
  localparam logic [15:0] TB_ID = 16'h5A17;
  localparam logic [3:0]  TB_REV = 4'h6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic cfg_unlocked;
  logic [7:0] cfg_ldn;
  logic [NDEV-1:0] dev_enable;
  logic [NDEV*16-1:0] dev_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_keyport #(.NUM_DEV(NDEV), .CHIP_ID(TB_ID), .CHIP_REV(TB_REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
    .cfg_ldn(cfg_ldn), .dev_enable(dev_enable), .dev_base(dev_base)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit m_locked;
  int m_kst;
  logic [7:0] m_idx, m_ldn;
  logic [NDEV-1:0] m_en;
  logic [15:0] m_base [NDEV];

  function automatic logic [7:0] key_byte(int p);
    return (p == 0) ? 8'h87 : (p == 1) ? 8'h01 : 8'h55;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    bit v = m_ldn < NDEV;
    if (m_locked) return 8'hFF;
    if (a == IDXP) return m_idx;
    if (a != DATP) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return TB_ID[15:8];
      8'h21: return TB_ID[7:0];
      8'h22: return {4'h0, TB_REV};
      8'h30: return v ? {7'b0, m_en[m_ldn[1:0]]} : 8'hFF;
      8'h60: return v ? m_base[m_ldn[1:0]][15:8] : 8'hFF;
      8'h61: return v ? m_base[m_ldn[1:0]][7:0] : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    bit v = m_ldn < NDEV;
    if (a == IDXP) begin
      if (m_locked) begin
        if (d == key_byte(m_kst)) begin
          if (m_kst == 3) begin m_locked = 0; m_kst = 0; end
          else m_kst++;
        end else m_kst = 0;
      end else m_idx = d;
    end else if (a == DATP && !m_locked) begin
      case (m_idx)
        8'h02: if (d == 8'h02) m_locked = 1;
        8'h07: m_ldn = d;
        8'h30: if (v) m_en[m_ldn[1:0]] = d[0];
        8'h60: if (v) m_base[m_ldn[1:0]][15:8] = d;
        8'h61: if (v) m_base[m_ldn[1:0]][7:0] = d;
        default: ;
      endcase
    end
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_outs(string req);
    check({req, " unlocked"}, 32'(cfg_unlocked), 32'(!m_locked));
    check({req, " ldn"}, 32'(cfg_ldn), 32'(m_ldn));
    check({req, " enable"}, 32'(dev_enable), 32'(m_en));
    for (int d = 0; d < NDEV; d++)
      check({req, " base"}, 32'(dev_base[d*16 +: 16]), 32'(m_base[d]));
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(string req, logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    check(req, 32'(io_rdata), 32'(exp_read(a)));
    io_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
  endtask

  function automatic logic [7:0] pick_idx();
    case ($urandom % 12)
      0: return 8'h02; 1: return 8'h07; 2: return 8'h20; 3: return 8'h21;
      4: return 8'h22; 5, 6: return 8'h30; 7: return 8'h60; 8: return 8'h61;
      9: return 8'h87; 10: return 8'h55;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_locked = 1; m_kst = 0; m_idx = 0; m_ldn = 0; m_en = '0;
    for (int d = 0; d < NDEV; d++) m_base[d] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state and idle read value
    check_outs("R1");
    @(negedge clk); io_addr = DATP; #1;
    check("R1 idle rdata", 32'(io_rdata), 32'hFF);

    // R3 locked: data writes ignored, reads FF
    wr(DATP, 8'h33);
    rd("R3 locked idx read", IDXP);
    rd("R3 locked data read", DATP);
    check_outs("R3");

    // R2 broken sequences must not unlock
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h87); wr(IDXP, 8'h01);
    wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    check("R2 broken key", 32'(cfg_unlocked), 32'(!m_locked));
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h87);
    wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    check("R2 late mismatch", 32'(cfg_unlocked), 32'(!m_locked));
    wr(16'h002D, 8'h00);
    unlock();
    check("R2 key unlock", 32'(cfg_unlocked), 32'd1);

    // R4 index readback, R7 identification
    wr(IDXP, 8'h20); rd("R4 index read", IDXP); rd("R7 id hi", DATP);
    wr(IDXP, 8'h21); rd("R7 id lo", DATP);
    wr(IDXP, 8'h22); wr(DATP, 8'hAB); rd("R7 rev", DATP);

    // R6 R8 R9 per-device registers
    for (int d = 0; d < NDEV; d++) begin
      wr(IDXP, 8'h07); wr(DATP, 8'(d)); rd("R6 ldn", DATP);
      wr(IDXP, 8'h30); wr(DATP, 8'hFE ^ 8'(d & 1)); rd("R8 act", DATP);
      wr(IDXP, 8'h60); wr(DATP, 8'h10 + 8'(d)); rd("R9 base hi", DATP);
      wr(IDXP, 8'h61); wr(DATP, 8'hC0 + 8'(d)); rd("R9 base lo", DATP);
      check_outs("R8 R9");
    end

    // R10 out of range selector and unknown index
    wr(IDXP, 8'h07); wr(DATP, 8'(NDEV));
    wr(IDXP, 8'h30); wr(DATP, 8'h01); rd("R10 act none", DATP);
    wr(IDXP, 8'h60); wr(DATP, 8'h77); rd("R10 base none", DATP);
    check_outs("R10");
    wr(IDXP, 8'h45); rd("R10 unknown idx", DATP);
    rd("R10 other addr", 16'h0030);

    // R5 exit
    wr(IDXP, 8'h02); wr(DATP, 8'h03);
    check("R5 non-exit value", 32'(cfg_unlocked), 32'd1);
    wr(DATP, 8'h02);
    check("R5 exit", 32'(cfg_unlocked), 32'd0);
    wr(IDXP, 8'h07); wr(DATP, 8'h01);
    unlock();
    rd("R3 index kept after lock", IDXP);
    check_outs("R3 locked writes");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 10;
      if (m_locked && ($urandom % 8 == 0)) unlock();
      else if (r < 3) wr(IDXP, pick_idx());
      else if (r < 6) wr(DATP, ($urandom % 4 == 0) ? 8'h02 : 8'($urandom));
      else if (r < 9) rd("R4 R6 R7 R8 R9 R10 random read", ($urandom % 2) ? DATP : IDXP);
      else wr(16'($urandom), 8'($urandom));
      if (i % 16 == 0) check_outs("R2 R3 R5 random");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule